// File: doc/BRIEF.md
# First-in first-out queue on a transparent synchronous RAM

This block is a single-clock first-in first-out queue. Its storage is an inferred dual-port array with a clocked write port and a clocked read port. A producer presents a word with `push`. A consumer watches `empty` and takes the word shown on `rdata` by raising `pop`. The queue reports `full` and its current occupancy on `level`. Both the read row and the write row wrap around the storage depth. Each pointer carries one extra wrap bit, so a full queue and an empty queue can be told apart when the row indices are equal.

The read port always addresses the row that will be the head after the current clock edge, so `rdata` shows the oldest stored word whenever `empty` is low. With `TRANSPARENT` set, a read that targets the row being written in the same cycle returns the incoming word. A word pushed into an empty queue can then be popped in the very next cycle. With `TRANSPARENT` cleared, the read sees the old row contents. To cover this, the flag logic holds `empty` asserted for one extra cycle, which gives a two-cycle push-to-pop latency.

Top module: `fifo_tq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `empty` is 1, `full` is 0 and `level` is 0. A reset in the middle of a run discards all stored words.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rdata` holds the oldest stored word. A pop accepted at a clock edge makes `rdata` show the next word in the following cycle.
- R3: `level` equals the number of stored words. It rises by one after an accepted push alone, falls by one after an accepted pop alone, and is unchanged after a cycle in which both a push and a pop are accepted.
- R4: `full` is 1 exactly when `level` equals `DEPTH`. A push while `full` is 1 is dropped, even in a cycle that also pops. A dropped push leaves the stored words unchanged.
- R5: A pop while `empty` is 1 is dropped. It leaves `level` and the read position unchanged, and the next word pushed is the next word returned.
- R6: With `TRANSPARENT`=1, a push into an empty queue makes `empty` 0 and puts that word on `rdata` in the very next cycle.
- R7: With `TRANSPARENT`=1, take a queue holding one word. A cycle that pops that word and pushes a new one writes the row that the next read addresses. In the next cycle `rdata` shows the new word.
- R8: With `TRANSPARENT`=0, a push into an empty queue raises `level` to 1 after one cycle, while `empty` stays 1. `empty` falls, with the word on `rdata`, one cycle later.
- R9: Ordering and occupancy stay correct after both pointers have wrapped past the end of the storage more than once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Store `wdata` at the tail this cycle |
| wdata | input | DW | Word to be stored |
| pop | input | 1 | Remove the head word this cycle |
| rdata | output | DW | Head word, valid while `empty` is 0 |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | No word available to pop |
| level | output | log2(DEPTH)+1 | Number of stored words |

## Verification
The assertions check the occupancy arithmetic on every cycle: the step of `level` for each combination of accepted push and pop, the hold of state on dropped pushes and pops, the tie between `full` and `level`, and the state after reset. They also check the latency from a push into an empty queue, which is one cycle with the bypass and two cycles without it. Only the bench's scenarios can show that the words come out in order and uncorrupted. This covers the same-row read-during-write, pointers that have wrapped several times, pushes dropped while full, and a reset in the middle of a run, all checked against a reference queue.

// File: rtl/fifo_tq_pkg.sv
package fifo_tq_pkg;

    // Accepted operation in a cycle: bit 0 = push taken, bit 1 = pop taken.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

    function automatic fifo_op_e op_decode(input logic push_ok, input logic pop_ok);
        return fifo_op_e'({pop_ok, push_ok});
    endfunction

    function automatic logic op_writes(input fifo_op_e op);
        return (op == OP_PUSH) || (op == OP_BOTH);
    endfunction

    function automatic logic op_reads(input fifo_op_e op);
        return (op == OP_POP) || (op == OP_BOTH);
    endfunction

    // Full when the wrap bits differ and the row indices agree.
    function automatic logic full_test(input logic wrap_differs, input logic rows_equal);
        return wrap_differs & rows_equal;
    endfunction

endpackage

// File: rtl/fifo_tq_ptr.sv
module fifo_tq_ptr #(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    output logic [AW:0] ptr,
    output logic [AW:0] ptr_next
);

    assign ptr_next = adv ? ptr + 1'b1 : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_next;
        end
    end

endmodule

// File: rtl/fifo_tq_ram.sv
module fifo_tq_ram #(
    parameter int DW          = 8,
    parameter int AW          = 3,
    parameter bit TRANSPARENT = 1'b1,
    localparam int ROWS       = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [ROWS];
    logic [DW-1:0] rd_word;

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    generate
        if (TRANSPARENT) begin : g_bypass
            // Same-row read during write returns the incoming word.
            assign rd_word = (we && (waddr == raddr)) ? wdata : store[raddr];
        end else begin : g_plain
            assign rd_word = store[raddr];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_word;
        end
    end

endmodule

// File: rtl/fifo_tq_flags.sv
module fifo_tq_flags
    import fifo_tq_pkg::*;
#(
    parameter int AW          = 3,
    parameter bit TRANSPARENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW:0] wr_ptr,
    input  logic [AW:0] wr_next,
    input  logic [AW:0] rd_next,
    output logic        full,
    output logic        empty,
    output logic [AW:0] level
);

    // Write position the reader may see after this edge. Without the
    // bypass, a row written this edge is readable one edge later.
    logic [AW:0] vis_wr;
    logic        full_d;

    assign vis_wr = TRANSPARENT ? wr_next : wr_ptr;
    assign full_d = full_test(wr_next[AW] != rd_next[AW],
                              wr_next[AW-1:0] == rd_next[AW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            full  <= 1'b0;
            empty <= 1'b1;
            level <= '0;
        end else begin
            full  <= full_d;
            empty <= (vis_wr == rd_next);
            level <= wr_next - rd_next;
        end
    end

endmodule

// File: rtl/fifo_tq.sv
module fifo_tq
    import fifo_tq_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter bit TRANSPARENT = 1'b1,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   level
);

    fifo_op_e    op;
    logic [AW:0] wr_ptr, wr_next;
    logic [AW:0] rd_ptr, rd_next;

    assign op = op_decode(push & ~full, pop & ~empty);

    fifo_tq_ptr #(.AW(AW)) u_wr_ptr (
        .clk      (clk),
        .rst      (rst),
        .adv      (op_writes(op)),
        .ptr      (wr_ptr),
        .ptr_next (wr_next)
    );

    fifo_tq_ptr #(.AW(AW)) u_rd_ptr (
        .clk      (clk),
        .rst      (rst),
        .adv      (op_reads(op)),
        .ptr      (rd_ptr),
        .ptr_next (rd_next)
    );

    fifo_tq_ram #(.DW(DW), .AW(AW), .TRANSPARENT(TRANSPARENT)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (op_writes(op)),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wdata),
        .raddr (rd_next[AW-1:0]),
        .rdata (rdata)
    );

    fifo_tq_flags #(.AW(AW), .TRANSPARENT(TRANSPARENT)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_ptr  (wr_ptr),
        .wr_next (wr_next),
        .rd_next (rd_next),
        .full    (full),
        .empty   (empty),
        .level   (level)
    );

    logic unused_rd_ptr;
    assign unused_rd_ptr = ^rd_ptr;

endmodule

// File: rtl/fifo_tq_chk.sv
module fifo_tq_chk #(
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter bit TRANSPARENT = 1'b1,
    localparam int AW         = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          push,
    input logic [DW-1:0] wdata,
    input logic          pop,
    input logic [DW-1:0] rdata,
    input logic          full,
    input logic          empty,
    input logic [AW:0]   level
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && !full && level == 0));

    a_r3_push_only: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (level == $past(level) + 1'b1));

    a_r3_pop_only: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=> (level == $past(level) - 1'b1));

    a_r3_both_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> $stable(level));

    a_r4_full_level: assert property (@(posedge clk) disable iff (rst)
        full |-> (level == DEPTH));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (full && $stable(level)));

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && level == 0 && !push) |=> (empty && level == 0));

    generate
        if (TRANSPARENT) begin : g_fast
            a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
                (empty && push) |=> (!empty && rdata == $past(wdata)));
        end else begin : g_slow
            a_r8_two_cycle: assert property (@(posedge clk) disable iff (rst)
                (empty && level == 0 && push) |=> (empty && level == 1) ##1 !empty);
        end
    endgenerate

endmodule

bind fifo_tq fifo_tq_chk #(
    .DW          (DW),
    .DEPTH       (DEPTH),
    .TRANSPARENT (TRANSPARENT)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (wdata),
    .pop   (pop),
    .rdata (rdata),
    .full  (full),
    .empty (empty),
    .level (level)
);

// File: tb/tb_fifo_tq.sv
`timescale 1ns/1ps
module tb_fifo_tq;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic          p;
        logic          q;
        logic [DW-1:0] d;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'hA0},   // push on empty
        '{1'b0, 1'b1, 8'h00},   // pop it
        '{1'b0, 1'b1, 8'h00},   // pop on empty
        '{1'b1, 1'b0, 8'hA1},
        '{1'b1, 1'b1, 8'hA2},   // push and pop, level stays 1
        '{1'b1, 1'b0, 8'hA3},
        '{1'b1, 1'b0, 8'hA4},
        '{1'b1, 1'b0, 8'hA5},
        '{1'b1, 1'b0, 8'hA6},
        '{1'b1, 1'b0, 8'hA7},
        '{1'b1, 1'b0, 8'hA8},
        '{1'b1, 1'b0, 8'hA9},   // now full
        '{1'b1, 1'b0, 8'hAA},   // dropped
        '{1'b1, 1'b1, 8'hAB},   // pop taken, push dropped
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 8'h00},   // empty again
        '{1'b0, 1'b1, 8'h00},   // pop on empty
        '{1'b1, 1'b0, 8'hB0},
        '{1'b1, 1'b0, 8'hB1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          push, pop;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          full, empty;
    logic [AW:0]   level;

    logic          nt_push;
    logic [DW-1:0] nt_wdata;
    logic [DW-1:0] nt_rdata;
    logic          nt_full, nt_empty;
    logic [AW:0]   nt_level;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [DW-1:0] mq [$];

    always #4 clk = ~clk;

    fifo_tq #(.DW(DW), .DEPTH(DEPTH), .TRANSPARENT(1'b1)) dut (
        .clk(clk), .rst(rst), .push(push), .wdata(wdata), .pop(pop),
        .rdata(rdata), .full(full), .empty(empty), .level(level)
    );

    fifo_tq #(.DW(DW), .DEPTH(DEPTH), .TRANSPARENT(1'b0)) dut_nt (
        .clk(clk), .rst(rst), .push(nt_push), .wdata(nt_wdata), .pop(1'b0),
        .rdata(nt_rdata), .full(nt_full), .empty(nt_empty), .level(nt_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the reference queue, compare.
    task automatic step(input string tag, input logic p, input logic q, input logic [DW-1:0] d);
        bit pok, qok;
        push  = p;
        pop   = q;
        wdata = d;
        pok = p && (mq.size() < DEPTH);
        qok = q && (mq.size() > 0);
        @(posedge clk);
        if (qok) void'(mq.pop_front());
        if (pok) mq.push_back(d);
        @(negedge clk);
        push = 1'b0;
        pop  = 1'b0;
        chk("R3 level", level, mq.size());
        chk("R4 full", full, mq.size() == DEPTH);
        chk({tag, " empty"}, empty, mq.size() == 0);
        if (mq.size() > 0) chk({tag, " rdata"}, rdata, mq[0]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 empty in reset", empty, 1);
        rst = 1'b0;
        mq.delete();
        @(negedge clk);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 level", level, 0);
        chk("R1 nt empty", nt_empty, 1);
        chk("R1 nt level", nt_level, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        push = 0; pop = 0; wdata = '0;
        nt_push = 0; nt_wdata = '0;
        @(negedge clk);
        do_reset();

        // Table walk (R2, R3, R4, R5 mixed patterns)
        for (int i = 0; i < NV; i++) begin
            step("R2", VEC[i].p, VEC[i].q, VEC[i].d);
        end

        // R9: steady stream through many wraps, level stays at 2
        for (int i = 0; i < 3 * DEPTH; i++) begin
            step("R9", 1'b1, 1'b1, 8'(8'hC0 + i));
        end
        chk("R9 level after wraps", level, 2);
        step("R9", 1'b0, 1'b1, 8'h00);
        step("R9", 1'b0, 1'b1, 8'h00);

        // R6: push into empty, word visible next cycle, pop right away
        step("R6", 1'b1, 1'b0, 8'h66);
        chk("R6 rdata one cycle", rdata, 8'h66);
        chk("R6 not empty", empty, 0);
        step("R6", 1'b0, 1'b1, 8'h00);

        // R7: one word held; pop it and push a new one into the read row
        step("R7", 1'b1, 1'b0, 8'h70);
        step("R7", 1'b1, 1'b1, 8'h71);
        chk("R7 same-row bypass", rdata, 8'h71);
        step("R7", 1'b0, 1'b1, 8'h00);

        // R5: pops on empty dropped, next push is next returned
        step("R5", 1'b0, 1'b1, 8'h00);
        step("R5", 1'b0, 1'b1, 8'h00);
        chk("R5 level after dropped pops", level, 0);
        step("R5", 1'b1, 1'b0, 8'h55);
        chk("R5 next word", rdata, 8'h55);

        // R4: fill, drop a push, drain and check stored words intact
        for (int i = 0; i < DEPTH - 1; i++) step("R4", 1'b1, 1'b0, 8'(8'h40 + i));
        chk("R4 full at depth", full, 1);
        step("R4", 1'b1, 1'b0, 8'hEE);
        chk("R4 level after drop", level, DEPTH);
        for (int i = 0; i < DEPTH; i++) step("R4", 1'b0, 1'b1, 8'h00);

        // R1: reset mid-run discards stored words
        step("R1", 1'b1, 1'b0, 8'h11);
        step("R1", 1'b1, 1'b0, 8'h12);
        do_reset();

        // R8: no bypass, two-cycle push-to-pop latency
        nt_push  = 1'b1;
        nt_wdata = 8'h88;
        @(posedge clk);
        @(negedge clk);
        nt_push = 1'b0;
        chk("R8 level after one", nt_level, 1);
        chk("R8 still empty", nt_empty, 1);
        @(negedge clk);
        chk("R8 empty falls", nt_empty, 0);
        chk("R8 rdata", nt_rdata, 8'h88);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule